// File: doc/BRIEF.md
# JTAG-Programmed One-Shot Pulse Generator

This block extends a test access port with two user instructions. Under the pulse instruction a serial data register is loaded from TDI while the TAP reports the shift state. On the update indication that value is copied into a shadow register. If the length field of the accepted value is nonzero, a single pulse is started on an independent system clock. The pulse lasts that many system-clock cycles. When the pulse ends, the request clears itself through a toggle handshake across the two clock domains, so one update gives exactly one pulse. No register is ever clocked from a mix of the two clocks.

Under the passthrough instruction the block does nothing in the capture and update states. While shifting it routes TDI straight to an output pin, so a host can draw arbitrary low pulses on that pin at TCK resolution. A write that arrives while a pulse is still in progress is dropped. The drop is recorded in a sticky flag that the host reads back on the next capture.

The TAP state machine is outside this block. It supplies the capture, shift and update indications, which are sampled on the rising edge of TCK, and the two instruction selects.

Top module: `jtag_pulse_trigger`

## Requirements
- R1: While `sel_pulse` and `shift_dr` are high, each rising TCK edge shifts the DR_W-bit data register one place toward bit 0 and enters TDI at the top bit. `tdo` always shows bit 0, so bits leave least significant first. Without `sel_pulse` the register does not move.
- R2: An update (`update_dr` with `sel_pulse`) while idle copies the data register into the shadow register. The low LEN_W bits of that copy (bits 5:0 by default) give the pulse length in system-clock cycles.
- R3: Each accepted update with a nonzero length gives exactly one high pulse on `pulse_out`. The pulse is exactly that many system-clock cycles wide.
- R4: An accepted update whose length field is zero produces no pulse.
- R5: An update that arrives while a previous request is still in flight is ignored. It does not change the shadow register and it does not start a pulse. The request counts as in flight until the pulse has ended and its acknowledge has reached the TCK domain.
- R6: A capture (`capture_dr` with `sel_pulse`) loads the data register with the sticky drop flag in bit 0 and zeros in every other bit, then clears the flag. The flag is set by every update ignored under R5.
- R7: While `sel_pass` and `shift_dr` are both high, `pass_pin` follows `tdi` combinationally. Shifting 1,0,1 therefore gives one low pulse one TCK period wide.
- R8: Whenever `sel_pass` or `shift_dr` is low, `pass_pin` is high. Capture and update under `sel_pass` have no effect on the pulse logic.
- R9: After reset, `pulse_out` is low, `tdo` is low and no pulse is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset for the TCK domain |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | TAP is in the capture state for a data register |
| shift_dr | input | 1 | TAP is in the shift state for a data register |
| update_dr | input | 1 | TAP is in the update state for a data register |
| sel_pulse | input | 1 | Pulse-register instruction is selected |
| sel_pass | input | 1 | Passthrough instruction is selected |
| tdo | output | 1 | Serial data out, bit 0 of the data register |
| pass_pin | output | 1 | TDI passthrough pin, high when idle |
| sys_clk | input | 1 | Independent system clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset for the system domain |
| pulse_out | output | 1 | Timed one-shot pulse |

## Verification
The case that needs care is a new update arriving in the TCK domain while the system domain is still timing the previous pulse, or while its acknowledge is still crossing back. The bench provokes it by starting a 63-cycle pulse and then scanning a second, short value straight away, so that its update lands in the middle of the running pulse. The run is judged correct if it shows only one pulse of the original width, the sticky flag reads 1 at the following capture and 0 at the capture after that, and a later write is accepted normally with its own width.

// File: rtl/jpt_pkg.sv
package jpt_pkg;
  // Default geometry of the user data register.
  localparam int DR_W_DEF  = 8;
  localparam int LEN_W_DEF = 6;
  localparam int SYNC_DEF  = 2;
endpackage

// File: rtl/jpt_rst_sync.sv
module jpt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/jpt_sync.sv
module jpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/jpt_user_dr.sv
module jpt_user_dr #(
  parameter int DR_W  = 8,
  parameter int LEN_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tdi,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  input  logic            sel,
  input  logic            ack_sync,
  output logic [DR_W-1:0] sr_q,
  output logic [DR_W-1:0] shadow_q,
  output logic            req_q,
  output logic            busy,
  output logic            tdo
);
  logic [DR_W-1:0] sr_d, shadow_d;
  logic            req_d, sticky_q, sticky_d;

  assign busy = req_q ^ ack_sync;
  assign tdo  = sr_q[0];

  always_comb begin
    sr_d     = sr_q;
    shadow_d = shadow_q;
    req_d    = req_q;
    sticky_d = sticky_q;
    if (sel) begin
      if (capture) begin
        sr_d     = '0;
        sr_d[0]  = sticky_q;
        sticky_d = 1'b0;
      end else if (shift) begin
        sr_d = {tdi, sr_q[DR_W-1:1]};
      end else if (update) begin
        if (busy) begin
          sticky_d = 1'b1;
        end else begin
          shadow_d = sr_q;
          if (sr_q[LEN_W-1:0] != '0) req_d = ~req_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      shadow_q <= '0;
      req_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      shadow_q <= shadow_d;
      req_q    <= req_d;
      sticky_q <= sticky_d;
    end
  end
endmodule

// File: rtl/jpt_oneshot.sv
module jpt_oneshot #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic [LEN_W-1:0] len,
  output logic             pulse_q,
  output logic             ack_q
);
  logic             seen_q, start;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             pulse_d, ack_d;

  assign start = req_s ^ seen_q;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = pulse_q;
    ack_d   = ack_q;
    if (start) begin
      cnt_d   = len;
      pulse_d = 1'b1;
    end else if (pulse_q) begin
      if (cnt_q == LEN_W'(1)) begin
        cnt_d   = '0;
        pulse_d = 1'b0;
        ack_d   = ~ack_q;
      end else begin
        cnt_d = cnt_q - LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      seen_q  <= req_s;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      ack_q   <= ack_d;
    end
  end
endmodule

// File: rtl/jtag_pulse_trigger.sv
module jtag_pulse_trigger #(
  parameter int DR_W   = jpt_pkg::DR_W_DEF,
  parameter int LEN_W  = jpt_pkg::LEN_W_DEF,
  parameter int SYNC_N = jpt_pkg::SYNC_DEF
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic sel_pulse,
  input  logic sel_pass,
  output logic tdo,
  output logic pass_pin,
  input  logic sys_clk,
  input  logic sys_rst_n,
  output logic pulse_out
);
  logic            tck_rst_n, sys_rst_s;
  logic [DR_W-1:0] sr_q, shadow_q;
  logic            req_tgl, ack_tgl, ack_tck, req_sys, busy;

  jpt_rst_sync u_rst_tck (.clk(tck),     .arst_n(trst_n),    .rst_n_o(tck_rst_n));
  jpt_rst_sync u_rst_sys (.clk(sys_clk), .arst_n(sys_rst_n), .rst_n_o(sys_rst_s));

  jpt_user_dr #(.DR_W(DR_W), .LEN_W(LEN_W)) u_dr (
    .clk(tck), .rst_n(tck_rst_n), .tdi(tdi), .capture(capture_dr),
    .shift(shift_dr), .update(update_dr), .sel(sel_pulse),
    .ack_sync(ack_tck), .sr_q(sr_q), .shadow_q(shadow_q),
    .req_q(req_tgl), .busy(busy), .tdo(tdo)
  );

  jpt_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(sys_clk), .rst_n(sys_rst_s), .d(req_tgl), .q(req_sys));

  jpt_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk(tck), .rst_n(tck_rst_n), .d(ack_tgl), .q(ack_tck));

  // Shadow is held constant from the request toggle until the ack returns,
  // so the length field is quasi-static when the system domain samples it.
  jpt_oneshot #(.LEN_W(LEN_W)) u_shot (
    .clk(sys_clk), .rst_n(sys_rst_s), .req_s(req_sys),
    .len(shadow_q[LEN_W-1:0]), .pulse_q(pulse_out), .ack_q(ack_tgl)
  );

  assign pass_pin = (sel_pass && shift_dr) ? tdi : 1'b1;
endmodule

// File: rtl/jpt_checker.sv
module jpt_checker #(
  parameter int DR_W  = 8,
  parameter int LEN_W = 6
) (
  input logic            tck,
  input logic            tck_rst_n,
  input logic            sys_clk,
  input logic            sys_rst_s,
  input logic            update_dr,
  input logic            sel_pulse,
  input logic [DR_W-1:0] sr_q,
  input logic [DR_W-1:0] shadow_q,
  input logic            req_tgl,
  input logic            busy,
  input logic            pulse_out,
  input logic            ack_tgl
);
  AST_SHADOW_LOAD: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (update_dr && sel_pulse && !busy) |=> shadow_q == $past(sr_q)); // R2

  AST_ACK_AT_END: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    $fell(pulse_out) |-> ack_tgl != $past(ack_tgl)); // R3

  AST_ZERO_NO_REQ: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (update_dr && sel_pulse && sr_q[LEN_W-1:0] == '0) |=> $stable(req_tgl)); // R4

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge tck) disable iff (!tck_rst_n)
    busy |=> $stable(req_tgl)); // R5

  AST_SHADOW_HELD: assert property (@(posedge tck) disable iff (!tck_rst_n)
    busy |=> $stable(shadow_q)); // R5
endmodule

bind jtag_pulse_trigger jpt_checker #(.DR_W(DR_W), .LEN_W(LEN_W)) u_chk (
  .tck(tck), .tck_rst_n(tck_rst_n), .sys_clk(sys_clk), .sys_rst_s(sys_rst_s),
  .update_dr(update_dr), .sel_pulse(sel_pulse), .sr_q(sr_q),
  .shadow_q(shadow_q), .req_tgl(req_tgl), .busy(busy),
  .pulse_out(pulse_out), .ack_tgl(ack_tgl)
);

// File: tb/jtag_pulse_trigger_test.sv
module jtag_pulse_trigger_test;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 40;
  localparam int NVEC = 5;
  localparam logic [7:0] VEC [NVEC] = '{8'h03, 8'h01, 8'h3F, 8'hC5, 8'h40};

  logic tck, trst_n, tdi, capture_dr, shift_dr, update_dr, sel_pulse, sel_pass;
  logic tdo, pass_pin, sys_clk, sys_rst_n, pulse_out;

  int n_chk, n_fail, run_len, last_w, n_pulse;
  logic done;

  jtag_pulse_trigger uut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .sel_pulse(sel_pulse),
    .sel_pass(sel_pass), .tdo(tdo), .pass_pin(pass_pin),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .pulse_out(pulse_out)
  );

  initial tck = 1'b0;
  always #(TCK_PERIOD/2) tck = ~tck;
  initial sys_clk = 1'b0;
  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  // Pulse monitor, sampled away from the system clock's active edge.
  always @(negedge sys_clk) begin
    if (pulse_out === 1'b1) run_len = run_len + 1;
    else if (run_len != 0) begin
      last_w  = run_len;
      n_pulse = n_pulse + 1;
      run_len = 0;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Capture, shift nbits, optional update, all under the pulse instruction.
  task automatic scan(input logic [15:0] v, input int nbits, input logic do_upd,
                      output logic [15:0] seen);
    seen = '0;
    @(negedge tck); sel_pulse = 1'b1; capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      tdi = v[i];
      seen[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 1'b0;
    if (do_upd) begin
      update_dr = 1'b1;
      @(negedge tck);
      update_dr = 1'b0;
    end
    sel_pulse = 1'b0;
  endtask

  task automatic wait_tck(input int n);
    for (int i = 0; i < n; i++) @(negedge tck);
  endtask

  initial begin
    #(TCK_PERIOD*20000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] seen;
    int base;
    done = 1'b0; n_chk = 0; n_fail = 0; run_len = 0; last_w = 0; n_pulse = 0;
    tdi = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    sel_pulse = 1'b0; sel_pass = 1'b0; trst_n = 1'b0; sys_rst_n = 1'b0;
    wait_tck(3);
    trst_n = 1'b1; sys_rst_n = 1'b1;
    wait_tck(4);

    // R9 reset state
    check(pulse_out === 1'b0, "R9 pulse_out", pulse_out, 0);
    check(tdo === 1'b0, "R9 tdo", tdo, 0);
    check(pass_pin === 1'b1, "R8 pass_pin idle", pass_pin, 1);
    check(n_pulse == 0, "R9 no pulse", n_pulse, 0);

    // Table walk: R2, R3, R4, R6 (sticky stays clear)
    for (int k = 0; k < NVEC; k++) begin
      base = n_pulse;
      scan({8'h00, VEC[k]}, 8, 1'b1, seen);
      check(seen[0] === 1'b0, "R6 sticky clear", seen[0], 0);
      wait_tck(40);
      check(n_pulse - base == ((VEC[k][5:0] != 0) ? 1 : 0), "R3/R4 pulse count",
            n_pulse - base, (VEC[k][5:0] != 0) ? 1 : 0);
      if (VEC[k][5:0] != 0)
        check(last_w == int'(VEC[k][5:0]), "R2/R3 pulse width", last_w, int'(VEC[k][5:0]));
    end

    // R1: 16 bits shifted, second half of tdo shows the first byte LSB first
    scan(16'h00A6, 16, 1'b0, seen);
    check(seen[15:8] === 8'hA6, "R1 shift order", int'(seen[15:8]), 'hA6);
    check(seen[7:0] === 8'h00, "R1 captured zeros", int'(seen[7:0]), 0);

    // R1: shift without sel_pulse does not move the register
    scan(16'h00FF, 8, 1'b0, seen);   // register now holds 0xFF
    @(negedge tck); shift_dr = 1'b1; tdi = 1'b0;
    wait_tck(3);
    shift_dr = 1'b0;
    check(tdo === 1'b1, "R1 gated shift", tdo, 1);

    // R5 / R6: update during a running pulse is dropped and flagged
    base = n_pulse;
    scan(16'h003F, 8, 1'b1, seen);
    scan(16'h0002, 8, 1'b1, seen);
    wait_tck(40);
    check(n_pulse - base == 1, "R5 single pulse", n_pulse - base, 1);
    check(last_w == 63, "R5 width kept", last_w, 63);
    base = n_pulse;
    scan(16'h0002, 8, 1'b1, seen);
    check(seen[0] === 1'b1, "R6 sticky set", seen[0], 1);
    wait_tck(40);
    check(n_pulse - base == 1, "R5 later write accepted", n_pulse - base, 1);
    check(last_w == 2, "R5 later width", last_w, 2);
    scan(16'h0000, 8, 1'b1, seen);
    check(seen[0] === 1'b0, "R6 sticky cleared", seen[0], 0);

    // R7 / R8 passthrough
    base = n_pulse;
    @(negedge tck); sel_pass = 1'b1; tdi = 1'b0;
    #1 check(pass_pin === 1'b1, "R8 no shift", pass_pin, 1);
    capture_dr = 1'b1; @(negedge tck); capture_dr = 1'b0;
    shift_dr = 1'b1; tdi = 1'b1;
    #1 check(pass_pin === 1'b1, "R7 bit 1", pass_pin, 1);
    @(negedge tck); tdi = 1'b0;
    #1 check(pass_pin === 1'b0, "R7 bit 0", pass_pin, 0);
    @(posedge tck); #1 check(pass_pin === 1'b0, "R7 low one TCK", pass_pin, 0);
    @(negedge tck); tdi = 1'b1;
    #1 check(pass_pin === 1'b1, "R7 bit 1 again", pass_pin, 1);
    @(negedge tck); shift_dr = 1'b0; tdi = 1'b0;
    #1 check(pass_pin === 1'b1, "R8 after shift", pass_pin, 1);
    update_dr = 1'b1; @(negedge tck); update_dr = 1'b0; sel_pass = 1'b0;
    wait_tck(40);
    check(n_pulse == base, "R8 update under passthrough", n_pulse, base);

    finish_run();
  end
endmodule